// File: doc/BRIEF.md
# Static Memory Strobe Timing Generator

This block produces the active-low chip-select, read-strobe and write-strobe waveforms for a single chip select of an external static memory port. A requester raises `start_i` together with a direction bit and four 32-bit timing words (setup, pulse, cycle and mode). The block latches them, decodes the compressed length fields into clock counts, and then counts through the access, lowering each strobe inside its own window and returning everything high when the total cycle length is reached.

Reads can be followed by a programmable bus float interval, during which the block stays busy and refuses new requests so that no other driver collides with the memory's output buffers. A one-clock `done_o` marks the last cycle of the whole operation, `sample_o` marks the last low cycle of whichever strobe times the transfer, and `doe_o` enables the data drivers for the full length of a write.

The controller is one state machine with three states: `ST_IDLE`, `ST_ACCESS` and `ST_FLOAT`. Its transitions are START (`ST_IDLE` to `ST_ACCESS` when `start_i` is high), ACCESS_END (`ST_ACCESS` to `ST_IDLE` on the last access cycle of a write, or of a read with zero float time), FLOAT_ENTER (`ST_ACCESS` to `ST_FLOAT` on the last access cycle of a read with non-zero float time) and FLOAT_END (`ST_FLOAT` to `ST_IDLE` on the last float cycle).

Top module: `strb_timing_gen`

## Requirements
- R1: After reset, and at any time no operation is running, `ncs_o`, `nrd_o` and `nwe_o` are high and `doe_o`, `sample_o`, `done_o` and `busy_o` are low.
- R2: Each 6-bit setup field decodes to 128 x bit5 + bits 4..0 clocks; in the setup word the write-strobe setup is bits 5..0, chip-select write setup 13..8, read-strobe setup 21..16, chip-select read setup 29..24.
- R3: Each 7-bit pulse field decodes to 128 x bit6 + bits 5..0 clocks, in the same byte lanes of the pulse word as the matching setup field (bits 6..0, 14..8, 22..16, 30..24).
- R4: The 9-bit cycle fields (write at bits 8..0, read at bits 24..16 of the cycle word) decode to 256 x bits 8..7 + bits 6..0 clocks; a decoded length of 0 is run as 1.
- R5: Counting access cycles k from 0 (the first cycle after the clock edge that takes `start_i`), a strobe is low exactly when setup <= k < setup + pulse and k < cycle length; it is forced high at the end of the cycle even if setup + pulse is larger.
- R6: A read uses the chip-select read fields and the read-strobe fields and never lowers `nwe_o`; a write uses the chip-select write fields and the write-strobe fields and never lowers `nrd_o`.
- R7: `sample_o` is high for one clock in the last low cycle of the controlling strobe: for reads mode bit 0 = 1 selects `nrd_o`, 0 selects `ncs_o`; for writes mode bit 1 = 1 selects `nwe_o`, 0 selects `ncs_o`. A zero-length controlling pulse gives no `sample_o`.
- R8: `doe_o` is high in every access cycle of a write and low during reads and float.
- R9: After a read, the float count in mode bits 19..16 (0 to 15) adds that many cycles in which `busy_o` stays high, all strobes stay high and `start_i` is ignored.
- R10: `done_o` is high for exactly one clock: the last access cycle, or the last float cycle when a read has a float time.
- R11: `start_i` is taken only while `busy_o` is low; the access starts in the next cycle, and requests made while busy have no effect on the outputs.
- R12: Timing words and direction are captured at the accepted request; changes to them during an operation do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request an access |
| write_i | input | 1 | Direction of the request: 1 write, 0 read |
| setup_i | input | 32 | Setup lengths word |
| pulse_i | input | 32 | Pulse lengths word |
| cycle_i | input | 32 | Total cycle lengths word |
| mode_i | input | 32 | Strobe selection and float time word |
| ncs_o | output | 1 | Chip select, active low |
| nrd_o | output | 1 | Read strobe, active low |
| nwe_o | output | 1 | Write strobe, active low |
| doe_o | output | 1 | Data output enable during writes |
| sample_o | output | 1 | Last low cycle of the controlling strobe |
| done_o | output | 1 | One-clock end-of-operation marker |
| busy_o | output | 1 | Operation in progress |

## Verification
All outputs are decoded from registered state, so a request taken at one rising edge shows its first access cycle (k = 0) in the clock period that follows that edge, `done_o` appears in period c for an access of c cycles, or in period c + f when a read has f float cycles, and `busy_o` is low again one period later. The bench keeps a queue of expected output vectors, one per clock period, built from the decoded lengths when its model sees a request in an idle period, and compares all seven outputs at every falling edge, where the period's values are settled. Requests made while the queue is non-empty are dropped by the model, which checks R9, R11 and R12 at the ports.

// File: rtl/strb_pkg.sv
`timescale 1ns/1ps
package strb_pkg;

    localparam int REG_W    = 32;
    localparam int CNT_W    = 10;
    localparam int TDF_W    = 4;
    localparam int SETUP_FW = 6;
    localparam int PULSE_FW = 7;
    localparam int CYCLE_FW = 9;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_FLOAT  = 2'd2
    } strb_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] ncs_set;
        logic [CNT_W-1:0] ncs_pul;
        logic [CNT_W-1:0] str_set;
        logic [CNT_W-1:0] str_pul;
        logic [CNT_W-1:0] cyc;
        logic [TDF_W-1:0] tdf;
        logic             ctrl_strobe;
        logic             is_write;
    } strb_cfg_t;

    // high bit weighs 128, low five bits are linear
    function automatic logic [CNT_W-1:0] dec_setup(input logic [SETUP_FW-1:0] f);
        return CNT_W'({f[SETUP_FW-1], 7'b0}) + CNT_W'(f[SETUP_FW-2:0]);
    endfunction

    // high bit weighs 128, low six bits are linear
    function automatic logic [CNT_W-1:0] dec_pulse(input logic [PULSE_FW-1:0] f);
        return CNT_W'({f[PULSE_FW-1], 7'b0}) + CNT_W'(f[PULSE_FW-2:0]);
    endfunction

    // top two bits weigh 256 each step, low seven bits are linear
    function automatic logic [CNT_W-1:0] dec_cycle(input logic [CYCLE_FW-1:0] f);
        return CNT_W'({f[CYCLE_FW-1:CYCLE_FW-2], 8'b0}) + CNT_W'(f[CYCLE_FW-3:0]);
    endfunction

endpackage

// File: rtl/strb_decode.sv
`timescale 1ns/1ps
module strb_decode
    import strb_pkg::*;
(
    input  logic             is_write,
    input  logic [REG_W-1:0] setup_word,
    input  logic [REG_W-1:0] pulse_word,
    input  logic [REG_W-1:0] cycle_word,
    input  logic [REG_W-1:0] mode_word,
    output strb_cfg_t        cfg
);
    // byte lanes shared by the setup and pulse words (R2, R3)
    localparam int LANE_STR_WR = 0;
    localparam int LANE_NCS_WR = 8;
    localparam int LANE_STR_RD = 16;
    localparam int LANE_NCS_RD = 24;
    localparam int CYC_WR_LSB  = 0;
    localparam int CYC_RD_LSB  = 16;
    localparam int TDF_LSB     = 16;
    localparam int MODE_RD_SEL = 0;
    localparam int MODE_WR_SEL = 1;

    logic [CNT_W-1:0] cyc_raw;

    always_comb begin
        cfg          = '0;
        cfg.is_write = is_write;
        if (is_write) begin
            cfg.ncs_set     = dec_setup(setup_word[LANE_NCS_WR +: SETUP_FW]);
            cfg.ncs_pul     = dec_pulse(pulse_word[LANE_NCS_WR +: PULSE_FW]);
            cfg.str_set     = dec_setup(setup_word[LANE_STR_WR +: SETUP_FW]);
            cfg.str_pul     = dec_pulse(pulse_word[LANE_STR_WR +: PULSE_FW]);
            cyc_raw         = dec_cycle(cycle_word[CYC_WR_LSB +: CYCLE_FW]);
            cfg.tdf         = '0;
            cfg.ctrl_strobe = mode_word[MODE_WR_SEL];
        end else begin
            cfg.ncs_set     = dec_setup(setup_word[LANE_NCS_RD +: SETUP_FW]);
            cfg.ncs_pul     = dec_pulse(pulse_word[LANE_NCS_RD +: PULSE_FW]);
            cfg.str_set     = dec_setup(setup_word[LANE_STR_RD +: SETUP_FW]);
            cfg.str_pul     = dec_pulse(pulse_word[LANE_STR_RD +: PULSE_FW]);
            cyc_raw         = dec_cycle(cycle_word[CYC_RD_LSB +: CYCLE_FW]);
            cfg.tdf         = mode_word[TDF_LSB +: TDF_W];
            cfg.ctrl_strobe = mode_word[MODE_RD_SEL];
        end
        // a zero length is run as a single cycle (R4)
        cfg.cyc = (cyc_raw == '0) ? CNT_W'(1) : cyc_raw;
    end

    logic unused_fields;
    assign unused_fields = ^{setup_word[7:6], setup_word[15:14], setup_word[23:22],
                             setup_word[31:30], pulse_word[7], pulse_word[15],
                             pulse_word[23], pulse_word[31], cycle_word[15:9],
                             cycle_word[31:25], mode_word[31:20], mode_word[15:2]};

endmodule

// File: rtl/strb_window.sv
`timescale 1ns/1ps
module strb_window #(
    parameter int W = 10
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] set_len,
    input  logic [W-1:0] pul_len,
    input  logic         at_last,
    output logic         low,
    output logic         ending
);
    logic [W:0] cnt_x;
    logic [W:0] stop_x;

    always_comb begin
        cnt_x  = {1'b0, cnt};
        stop_x = {1'b0, set_len} + {1'b0, pul_len};
        low    = (cnt_x >= {1'b0, set_len}) && (cnt_x < stop_x);
        // last low cycle: window closes next cycle or the access ends now
        ending = low && (at_last || ((cnt_x + (W+1)'(1)) == stop_x));
    end

endmodule

// File: rtl/strb_timing_gen.sv
`timescale 1ns/1ps
module strb_timing_gen
    import strb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             write_i,
    input  logic [REG_W-1:0] setup_i,
    input  logic [REG_W-1:0] pulse_i,
    input  logic [REG_W-1:0] cycle_i,
    input  logic [REG_W-1:0] mode_i,
    output logic             ncs_o,
    output logic             nrd_o,
    output logic             nwe_o,
    output logic             doe_o,
    output logic             sample_o,
    output logic             done_o,
    output logic             busy_o
);
    localparam int N_WIN   = 2;
    localparam int WIN_NCS = 0;
    localparam int WIN_STR = 1;

    strb_state_t      state_q, state_d;
    strb_cfg_t        cfg_q, cfg_dec;
    logic [CNT_W-1:0] k_q;
    logic [TDF_W-1:0] f_q;

    logic             at_last, f_last, need_float;
    logic [CNT_W-1:0] win_set [N_WIN];
    logic [CNT_W-1:0] win_pul [N_WIN];
    logic [N_WIN-1:0] win_low, win_end;

    strb_decode u_decode (
        .is_write   (write_i),
        .setup_word (setup_i),
        .pulse_word (pulse_i),
        .cycle_word (cycle_i),
        .mode_word  (mode_i),
        .cfg        (cfg_dec)
    );

    assign win_set[WIN_NCS] = cfg_q.ncs_set;
    assign win_pul[WIN_NCS] = cfg_q.ncs_pul;
    assign win_set[WIN_STR] = cfg_q.str_set;
    assign win_pul[WIN_STR] = cfg_q.str_pul;

    generate
        for (genvar g = 0; g < N_WIN; g++) begin : g_win
            strb_window #(.W(CNT_W)) u_win (
                .cnt     (k_q),
                .set_len (win_set[g]),
                .pul_len (win_pul[g]),
                .at_last (at_last),
                .low     (win_low[g]),
                .ending  (win_end[g])
            );
        end
    endgenerate

    assign at_last    = (k_q == cfg_q.cyc - CNT_W'(1));
    assign f_last     = (f_q == cfg_q.tdf - TDF_W'(1));
    assign need_float = !cfg_q.is_write && (cfg_q.tdf != '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_ACCESS;          // START
            ST_ACCESS: if (at_last) state_d = need_float ? ST_FLOAT  // FLOAT_ENTER
                                                         : ST_IDLE;  // ACCESS_END
            ST_FLOAT:  if (f_last)  state_d = ST_IDLE;             // FLOAT_END
            default:                state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counters and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            k_q   <= '0;
            f_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) cfg_q <= cfg_dec;
                    k_q <= '0;
                    f_q <= '0;
                end
                ST_ACCESS: begin
                    k_q <= k_q + CNT_W'(1);
                    f_q <= '0;
                end
                ST_FLOAT: begin
                    f_q <= f_q + TDF_W'(1);
                end
                default: begin
                    k_q <= '0;
                    f_q <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        ncs_o    = 1'b1;
        nrd_o    = 1'b1;
        nwe_o    = 1'b1;
        doe_o    = 1'b0;
        sample_o = 1'b0;
        done_o   = 1'b0;
        busy_o   = 1'b1;
        unique case (state_q)
            ST_IDLE: busy_o = 1'b0;
            ST_ACCESS: begin
                ncs_o    = !win_low[WIN_NCS];
                nrd_o    = !(win_low[WIN_STR] && !cfg_q.is_write);
                nwe_o    = !(win_low[WIN_STR] &&  cfg_q.is_write);
                doe_o    = cfg_q.is_write;
                sample_o = cfg_q.ctrl_strobe ? win_end[WIN_STR] : win_end[WIN_NCS];
                done_o   = at_last && !need_float;
            end
            ST_FLOAT: done_o = f_last;
            default:  busy_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/strb_timing_gen_chk.sv
`timescale 1ns/1ps
module strb_timing_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic ncs_o,
    input logic nrd_o,
    input logic nwe_o,
    input logic doe_o,
    input logic sample_o,
    input logic done_o,
    input logic busy_o
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (ncs_o && nrd_o && nwe_o && !doe_o && !sample_o && !done_o));

    assert_strobe_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nrd_o && !nwe_o));

    assert_sample_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> (!ncs_o || !nrd_o || !nwe_o));

    assert_doe_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        doe_o |-> nrd_o);

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    assert_done_inside_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    assert_done_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    assert_start_taken_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

endmodule

bind strb_timing_gen strb_timing_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .ncs_o    (ncs_o),
    .nrd_o    (nrd_o),
    .nwe_o    (nwe_o),
    .doe_o    (doe_o),
    .sample_o (sample_o),
    .done_o   (done_o),
    .busy_o   (busy_o)
);

// File: tb/strb_timing_gen_test.sv
`timescale 1ns/1ps
module strb_timing_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        write_i = 1'b0;
    logic [31:0] setup_i = '0, pulse_i = '0, cycle_i = '0, mode_i = '0;
    logic        ncs_o, nrd_o, nwe_o, doe_o, sample_o, done_o, busy_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;
    string scen = "R1";

    // expected vector: {busy, ncs, nrd, nwe, doe, sample, done}
    logic [6:0] exp_q [$];
    localparam logic [6:0] IDLE_VEC = 7'b0111000;

    always #(CLK_PERIOD/2) clk = ~clk;

    strb_timing_gen uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i),
        .setup_i(setup_i), .pulse_i(pulse_i), .cycle_i(cycle_i), .mode_i(mode_i),
        .ncs_o(ncs_o), .nrd_o(nrd_o), .nwe_o(nwe_o), .doe_o(doe_o),
        .sample_o(sample_o), .done_o(done_o), .busy_o(busy_o)
    );

    function automatic int d_setup(input logic [5:0] f);
        return 128 * int'(f[5]) + int'(f[4:0]);
    endfunction
    function automatic int d_pulse(input logic [6:0] f);
        return 128 * int'(f[6]) + int'(f[5:0]);
    endfunction
    function automatic int d_cycle(input logic [8:0] f);
        return 256 * int'(f[8:7]) + int'(f[6:0]);
    endfunction
    function automatic bit inside_win(input int k, input int s, input int p);
        return (k >= s) && (k < s + p);
    endfunction

    // builds one expected vector per clock period of the accepted operation
    task automatic build(input logic wr, input logic [31:0] su, pu, cy, mo);
        int sn, pn, ss, ps, c, tdf;
        bit ctrl;
        sn   = wr ? d_setup(su[13:8]) : d_setup(su[29:24]);
        pn   = wr ? d_pulse(pu[14:8]) : d_pulse(pu[30:24]);
        ss   = wr ? d_setup(su[5:0])  : d_setup(su[21:16]);
        ps   = wr ? d_pulse(pu[6:0])  : d_pulse(pu[22:16]);
        c    = wr ? d_cycle(cy[8:0])  : d_cycle(cy[24:16]);
        if (c == 0) c = 1;
        tdf  = wr ? 0 : int'(mo[19:16]);
        ctrl = wr ? mo[1] : mo[0];
        for (int k = 0; k < c; k++) begin
            bit nl, sl, cl, cn, smp, dn;
            nl  = inside_win(k, sn, pn);
            sl  = inside_win(k, ss, ps);
            cl  = ctrl ? sl : nl;
            cn  = ctrl ? inside_win(k + 1, ss, ps) : inside_win(k + 1, sn, pn);
            smp = cl && ((k == c - 1) || !cn);
            dn  = (k == c - 1) && (tdf == 0);
            exp_q.push_back({1'b1, !nl, !(sl && !wr), !(sl && wr), wr, smp, dn});
        end
        for (int f = 0; f < tdf; f++)
            exp_q.push_back({1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, (f == tdf - 1)});
    endtask

    task automatic check_bit(input string name, input string req,
                             input logic act, input logic exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s (%s, case %s) at t=%0t: actual=%b expected=%b",
                     req, name, scen, $time, act, exp_v);
        end
    endtask

    task automatic compare_now();
        logic [6:0] e;
        e = (exp_q.size() > 0) ? exp_q[0] : IDLE_VEC;
        check_bit("busy_o",   "R11", busy_o,   e[6]);
        check_bit("ncs_o",    "R5",  ncs_o,    e[5]);
        check_bit("nrd_o",    "R6",  nrd_o,    e[4]);
        check_bit("nwe_o",    "R6",  nwe_o,    e[3]);
        check_bit("doe_o",    "R8",  doe_o,    e[2]);
        check_bit("sample_o", "R7",  sample_o, e[1]);
        check_bit("done_o",   "R10", done_o,   e[0]);
    endtask

    // called at a falling edge: check this period, advance model, drive next inputs
    task automatic step(input logic st, input logic wr,
                        input logic [31:0] su, pu, cy, mo);
        compare_now();
        if (exp_q.size() > 0) void'(exp_q.pop_front());
        else if (st)          build(wr, su, pu, cy, mo);
        start_i = st; write_i = wr;
        setup_i = su; pulse_i = pu; cycle_i = cy; mode_i = mo;
        @(negedge clk);
    endtask

    task automatic idle_steps(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0, '0, '0);
    endtask

    task automatic run_op(input string tag, input logic wr,
                          input logic [31:0] su, pu, cy, mo);
        scen = tag;
        step(1'b1, wr, su, pu, cy, mo);
        while (exp_q.size() > 0) step(1'b0, 1'b0, '0, '0, '0, '0);
        idle_steps(2);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired at t=%0t", $time);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: quiet after reset
        scen = "R1";
        idle_steps(3);

        // default programming, single-cycle read and write (R4, R10)
        run_op("R4_default_read",  1'b0, 32'h0, 32'h01010101, 32'h00010001, 32'h10001000);
        run_op("R4_default_write", 1'b1, 32'h0, 32'h01010101, 32'h00010001, 32'h10001000);

        // write timed by write strobe, R5 windows and R8 data enable
        run_op("R5_write_nwe", 1'b1, 32'h0000_0102, 32'h0000_0503, 32'h0000_0008, 32'h2);
        // write timed by chip select
        run_op("R7_write_ncs", 1'b1, 32'h0000_0201, 32'h0000_0302, 32'h0000_0007, 32'h0);
        // read timed by read strobe, no float
        run_op("R6_read_nrd", 1'b0, 32'h0102_0000, 32'h0404_0000, 32'h0006_0000, 32'h1);
        // read timed by chip select with 3 float cycles (R9)
        run_op("R9_read_float", 1'b0, 32'h0000_0000, 32'h0502_0000, 32'h0006_0000, 32'h0003_0000);
        // pulse past the end of the cycle is clipped (R5)
        run_op("R5_clip", 1'b1, 32'h0000_0004, 32'h0000_0A0A, 32'h0000_0006, 32'h2);
        // zero cycle length runs one cycle (R4)
        run_op("R4_zero_cycle", 1'b0, 32'h0, 32'h0101_0000, 32'h0, 32'h1);
        // zero controlling pulse: no sample (R7)
        run_op("R7_zero_pulse", 1'b1, 32'h0, 32'h0000_0200, 32'h0000_0004, 32'h2);
        // high-weight encodings: setup 129, pulse 130 and 129, cycle 261 (R2, R3, R4)
        run_op("R2_R3_high_bits", 1'b1, 32'h0000_0021, 32'h0000_4142, 32'h0000_0085, 32'h2);
        // high read cycle field: bits 8..7 = 2 gives 512+3 (R4)
        run_op("R4_read_high", 1'b0, 32'h2100_0000, 32'h0142_0000, 32'h0103_0000, 32'h0);

        // R11 and R12: requests and new words during an operation are ignored
        scen = "R12_busy_requests";
        step(1'b1, 1'b1, 32'h0000_0301, 32'h0000_0405, 32'h0000_0014, 32'h2);
        for (int i = 0; i < 25; i++)
            step(1'b1, 1'b0, 32'h1F1F_1F1F, 32'h3F3F_3F3F, 32'h0001_0001, 32'h000F_0001);
        idle_steps(4);

        // R9: continuous requests during float are held off until idle
        scen = "R9_float_block";
        step(1'b1, 1'b0, 32'h0001_0000, 32'h0203_0000, 32'h0005_0000, 32'h0004_0001);
        for (int i = 0; i < 14; i++)
            step(1'b1, 1'b1, 32'h0, 32'h0000_0101, 32'h0000_0002, 32'h2);
        idle_steps(4);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule